// File: doc/BRIEF.md
# Sixteen-Bit Capture Timer

This block is a free-running 16-bit up-counter with an input-capture unit, reached over an 8-bit register bus. When the chosen edge appears on the capture pin, the current count is copied into a capture register and a capture flag is raised. Software measures pulse widths by reading the captured values and, for duty-cycle measurement, switching the edge polarity between captures.

The capture pin is brought into the clock domain by a synchronizer. An optional filter then accepts a new level only after it has been seen on several consecutive samples. The counter sets an overflow flag each time it wraps, so software can extend a measurement past the counter range.

Both halves of a 16-bit value pass through one shared temporary byte. Reading a low byte freezes the matching high byte, and writing a high byte stages it. As a result, every 16-bit transfer acts on a single consistent value, even though the counter keeps moving between the two bus accesses.

Top module: `cap_timer16`

## Requirements
- R1: When the run bit (control register at address 4, bit 0) is set, the count increases by one on every clock and wraps from 0xFFFF to 0x0000. When the run bit is clear, the count holds.
- R2: A write to a high-byte address (1 or 3) only loads the temporary byte and leaves the count unchanged. A write to the count low byte (address 0) loads the count with {temporary byte, written byte} on that clock, and no increment takes place on that clock.
- R3: A read of a low byte (address 0 for the count, 2 for the capture register) returns the low byte and, on the same clock, copies the matching high byte into the temporary byte. A read of a high-byte address (1 or 3) returns the temporary byte.
- R4: The overflow flag (flag register at address 5, bit 0, also driven on `ovfFlag`) is set on the clock where the running count wraps from 0xFFFF to 0x0000.
- R5: Writing a one to a bit of the flag register clears that flag. Writing a zero leaves the flag unchanged.
- R6: With the filter off, a selected pin transition stores the count value held during the second clock after the pin changed into the capture register. On the same clock it sets the capture flag (address 5, bit 1, also driven on `capFlag`). Counted from a count load, a change applied before the first following edge captures the loaded value plus 2.
- R7: The edge bit (address 4, bit 1) selects the edge: 1 means rising and 0 means falling. A transition in the other direction leaves both the capture register and the capture flag unchanged.
- R8: The filter enable bit (address 4, bit 2) delays capture by four more clocks, so the value stored is the loaded value plus 6. With the filter on, a pin pulse shorter than four clocks causes no capture.
- R9: After reset, the count, the capture register, the control register and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| capPin | input | 1 | Capture pin, asynchronous to the clock |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe for one clock |
| busRd | input | 1 | Read strobe for one clock |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| ovfFlag | output | 1 | Overflow flag |
| capFlag | output | 1 | Capture flag |

## Verification
The bench first reads the counter low byte just before the count crosses from 0x12FF to 0x1300. A design that did not freeze the high byte would return 0x13 instead of 0x12. It also writes a high byte and then reads the counter back, which exposes a design that lets the staged byte reach the count early.

Capture latency is checked one clock before and on the expected clock, and the stored value is compared against the load value plus 2 or plus 6. These checks include load values that wrap through 0xFFFF and that cross a byte boundary, so an off-by-one in the synchronizer or filter depth shows up as a wrong captured value.

Transitions in the unselected direction must leave the capture register untouched. A two-clock glitch must be rejected with the filter on and captured with it off. Writing zeros to the flag register must not clear the flags.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [2:0] {
    ADDR_CNT_LO = 3'd0,
    ADDR_CNT_HI = 3'd1,
    ADDR_CAP_LO = 3'd2,
    ADDR_CAP_HI = 3'd3,
    ADDR_CTRL   = 3'd4,
    ADDR_FLAG   = 3'd5
  } regAddr_e;

  localparam int CTRL_W    = 3;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_RISE = 1;
  localparam int CTRL_FILT = 2;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_CAP = 1;

  typedef struct packed {
    logic cntLoad;
    logic tempFromBus;
    logic tempFromCnt;
    logic tempFromCap;
    logic clrOvf;
    logic clrCap;
  } ctrlStrb_t;

endpackage

// File: rtl/ict_capin.sv
module ict_capin #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capPin,
  input  logic filtEn,
  input  logic riseSel,
  output logic capEvt
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic                   rawPrev;
  logic [FILT_LEN-1:0]    hist;
  logic                   filtLvl;
  logic                   allHigh;
  logic                   allLow;
  logic                   rawChg;
  logic                   filtChg;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[gi] <= 1'b0;
          else        syncQ[gi] <= capPin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[gi] <= 1'b0;
          else        syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rawPrev <= 1'b0;
      hist    <= '0;
      filtLvl <= 1'b0;
    end else begin
      rawPrev <= syncOut;
      hist    <= {hist[FILT_LEN-2:0], syncOut};
      if (allHigh)     filtLvl <= 1'b1;
      else if (allLow) filtLvl <= 1'b0;
    end
  end

  always_comb begin
    allHigh = &hist;
    allLow  = ~|hist;
    rawChg  = (syncOut != rawPrev);
    filtChg = (allHigh && !filtLvl) || (allLow && filtLvl);
    if (filtEn) capEvt = filtChg && (allHigh == riseSel);
    else        capEvt = rawChg && (syncOut == riseSel);
  end

endmodule

// File: rtl/ict_busctl.sv
module ict_busctl
  import ict_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  capVal,
  input  logic [BUS_W-1:0]  tempVal,
  input  logic              ovfFlag,
  input  logic              capFlag,
  output ctrlStrb_t         strb,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic [BUS_W-1:0]  busRdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrlVal <= '0;
    else if (busWr && busAddr == ADDR_CTRL)
      ctrlVal <= busWdata[CTRL_W-1:0];
  end

  always_comb begin
    strb             = '0;
    strb.cntLoad     = busWr && (busAddr == ADDR_CNT_LO);
    strb.tempFromBus = busWr && ((busAddr == ADDR_CNT_HI) || (busAddr == ADDR_CAP_HI));
    strb.tempFromCnt = busRd && (busAddr == ADDR_CNT_LO);
    strb.tempFromCap = busRd && (busAddr == ADDR_CAP_LO);
    strb.clrOvf      = busWr && (busAddr == ADDR_FLAG) && busWdata[FLAG_OVF];
    strb.clrCap      = busWr && (busAddr == ADDR_FLAG) && busWdata[FLAG_CAP];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CNT_LO: busRdata = cntVal[BUS_W-1:0];
      ADDR_CNT_HI: busRdata = tempVal;
      ADDR_CAP_LO: busRdata = capVal[BUS_W-1:0];
      ADDR_CAP_HI: busRdata = tempVal;
      ADDR_CTRL:   busRdata = {{(BUS_W-CTRL_W){1'b0}}, ctrlVal};
      ADDR_FLAG:   busRdata = {{(BUS_W-2){1'b0}}, capFlag, ovfFlag};
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/ict_datapath.sv
module ict_datapath
  import ict_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capPin,
  input  logic [BUS_W-1:0]  busWdata,
  input  ctrlStrb_t         strb,
  input  logic [CTRL_W-1:0] ctrlVal,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  capVal,
  output logic [BUS_W-1:0]  tempVal,
  output logic              ovfFlag,
  output logic              capFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic runEn;
  logic wrapEvt;
  logic capEvt;

  assign runEn   = ctrlVal[CTRL_RUN];
  assign wrapEvt = runEn && !strb.cntLoad && (cntVal == CNT_MAX);

  ict_capin #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) capin_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .capPin (capPin),
    .filtEn (ctrlVal[CTRL_FILT]),
    .riseSel(ctrlVal[CTRL_RISE]),
    .capEvt (capEvt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cntVal <= '0;
    else if (strb.cntLoad)  cntVal <= {tempVal, busWdata};
    else if (runEn)         cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tempVal <= '0;
    else if (strb.tempFromBus) tempVal <= busWdata;
    else if (strb.tempFromCnt) tempVal <= cntVal[CNT_W-1:BUS_W];
    else if (strb.tempFromCap) tempVal <= capVal[CNT_W-1:BUS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      capVal <= '0;
    else if (capEvt) capVal <= cntVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovfFlag <= 1'b0;
      capFlag <= 1'b0;
    end else begin
      ovfFlag <= wrapEvt | (ovfFlag & ~strb.clrOvf);
      capFlag <= capEvt  | (capFlag & ~strb.clrCap);
    end
  end

endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
  import ict_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capPin,
  input  logic [2:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             ovfFlag,
  output logic             capFlag
);

  localparam int CNT_W = 2 * BUS_W;

  ctrlStrb_t         strb;
  logic [CTRL_W-1:0] ctrlVal;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  capVal;
  logic [BUS_W-1:0]  tempVal;

  ict_busctl #(.BUS_W(BUS_W)) busctl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .busWdata(busWdata),
    .cntVal  (cntVal),
    .capVal  (capVal),
    .tempVal (tempVal),
    .ovfFlag (ovfFlag),
    .capFlag (capFlag),
    .strb    (strb),
    .ctrlVal (ctrlVal),
    .busRdata(busRdata)
  );

  ict_datapath #(
    .BUS_W      (BUS_W),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) datapath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .capPin  (capPin),
    .busWdata(busWdata),
    .strb    (strb),
    .ctrlVal (ctrlVal),
    .cntVal  (cntVal),
    .capVal  (capVal),
    .tempVal (tempVal),
    .ovfFlag (ovfFlag),
    .capFlag (capFlag)
  );

endmodule

// File: rtl/ict_checker.sv
module ict_checker
  import ict_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        busAddr,
  input logic              busWr,
  input logic [BUS_W-1:0]  busWdata,
  input logic [CTRL_W-1:0] ctrlVal,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  capVal,
  input logic [BUS_W-1:0]  tempVal,
  input logic              ovfFlag,
  input logic              capFlag
);

  logic loadCyc;
  logic ovfClrCyc;
  assign loadCyc   = busWr && (busAddr == ADDR_CNT_LO);
  assign ovfClrCyc = busWr && (busAddr == ADDR_FLAG) && busWdata[FLAG_OVF];

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlVal[CTRL_RUN] && !loadCyc) |=> (cntVal == $past(cntVal) + {{(CNT_W-1){1'b0}}, 1'b1})); // R1

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlVal[CTRL_RUN] && !loadCyc) |=> $stable(cntVal)); // R1

  AST_ATOMIC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    loadCyc |=> (cntVal == {$past(tempVal), $past(busWdata)})); // R2

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlVal[CTRL_RUN] && !loadCyc && (cntVal == {CNT_W{1'b1}})) |=> ovfFlag); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !ovfClrCyc) |=> ovfFlag); // R5

  AST_CAPTURE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capVal) |-> capFlag); // R6

endmodule

bind cap_timer16 ict_checker #(.BUS_W(BUS_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busWdata(busWdata),
  .ctrlVal (ctrlVal),
  .cntVal  (cntVal),
  .capVal  (capVal),
  .tempVal (tempVal),
  .ovfFlag (ovfFlag),
  .capFlag (capFlag)
);

// File: tb/cap_timer16_tb_top.sv
module cap_timer16_tb_top;
  import ict_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       capPin;
  logic [2:0] busAddr;
  logic       busWr;
  logic       busRd;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic       ovfFlag;
  logic       capFlag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cap_timer16 dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .capPin  (capPin),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .ovfFlag (ovfFlag),
    .capFlag (capFlag)
  );

  // {filter, rising, new pin level, load value}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b0, 1'b1, 1'b1, 16'h1000},
    {1'b0, 1'b1, 1'b0, 16'h2000},
    {1'b0, 1'b0, 1'b0, 16'h3000},
    {1'b1, 1'b1, 1'b1, 16'h40F0},
    {1'b1, 1'b0, 1'b0, 16'h5555},
    {1'b1, 1'b0, 1'b1, 16'h6000},
    {1'b0, 1'b1, 1'b1, 16'hFFFF},
    {1'b1, 1'b1, 1'b1, 16'h00FA}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All bus tasks start and end on a falling edge.
  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr  = a;
    busWdata = d;
    busWr    = 1'b1;
    @(negedge clk);
    busWr    = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busAddr = a;
    busRd   = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd   = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [15:0] base;
    logic [15:0] expv;
    logic [15:0] ldv;
    logic        filt;
    logic        rise;
    logic        nlv;
    logic        match;
    int          lat;

    rst_n = 1'b0; capPin = 1'b0; busAddr = '0; busWr = 1'b0; busRd = 1'b0; busWdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 ovfFlag", {15'd0, ovfFlag}, 16'd0);
    chk("R9 capFlag", {15'd0, capFlag}, 16'd0);
    busRead(ADDR_CTRL, lo);   chk("R9 control", {8'd0, lo}, 16'd0);
    busRead(ADDR_FLAG, lo);   chk("R9 flags", {8'd0, lo}, 16'd0);
    busRead(ADDR_CAP_LO, lo); busRead(ADDR_CAP_HI, hi);
    chk("R9 capture", {hi, lo}, 16'd0);
    // R1 run clear after reset: count holds at zero
    repeat (5) @(negedge clk);
    busRead(ADDR_CNT_LO, lo); busRead(ADDR_CNT_HI, hi);
    chk("R1 hold after reset", {hi, lo}, 16'd0);

    // R1 stopped counter holds a loaded value
    busWrite(ADDR_CNT_HI, 8'h02); busWrite(ADDR_CNT_LO, 8'h03);
    repeat (5) @(negedge clk);
    busRead(ADDR_CNT_LO, lo); busRead(ADDR_CNT_HI, hi);
    chk("R1 hold loaded", {hi, lo}, 16'h0203);

    // R2 high-byte write alone leaves the count untouched
    busWrite(ADDR_CNT_HI, 8'hAB);
    busRead(ADDR_CNT_LO, lo); busRead(ADDR_CNT_HI, hi);
    chk("R2 high write staged only", {hi, lo}, 16'h0203);

    // R2/R3/R1 running: atomic read across a byte carry
    busWrite(ADDR_CTRL, 8'h01);
    busWrite(ADDR_CNT_HI, 8'h12); busWrite(ADDR_CNT_LO, 8'hFF);
    busRead(ADDR_CNT_LO, lo);
    chk("R2 no increment on load cycle", {8'd0, lo}, 16'h00FF);
    busRead(ADDR_CNT_HI, hi);
    chk("R3 high byte frozen by low read", {8'd0, hi}, 16'h0012);
    busRead(ADDR_CNT_LO, lo);
    chk("R1 increments per clock", {8'd0, lo}, 16'h0001);

    // R4 overflow at wrap
    busWrite(ADDR_FLAG, 8'h03);
    busWrite(ADDR_CNT_HI, 8'hFF); busWrite(ADDR_CNT_LO, 8'hFE);
    @(negedge clk);
    chk("R4 no flag before wrap", {15'd0, ovfFlag}, 16'd0);
    @(negedge clk);
    chk("R4 flag at wrap", {15'd0, ovfFlag}, 16'd1);
    // R5 write-one-to-clear
    busWrite(ADDR_FLAG, 8'h00);
    chk("R5 zero write keeps ovf", {15'd0, ovfFlag}, 16'd1);
    busWrite(ADDR_FLAG, 8'h02);
    chk("R5 other bit keeps ovf", {15'd0, ovfFlag}, 16'd1);
    busWrite(ADDR_FLAG, 8'h01);
    busRead(ADDR_FLAG, lo);
    chk("R5 ovf cleared", {8'd0, lo}, 16'd0);

    // R6 R7 R8 table of capture scenarios
    for (int i = 0; i < 8; i++) begin
      filt = VEC[i][18];
      rise = VEC[i][17];
      nlv  = VEC[i][16];
      ldv  = VEC[i][15:0];
      match = (nlv == rise);
      lat  = filt ? 8 : 4;
      capPin = ~nlv;
      repeat (8) @(negedge clk);
      busRead(ADDR_CAP_LO, lo); busRead(ADDR_CAP_HI, hi);
      base = {hi, lo};
      busWrite(ADDR_FLAG, 8'h03);
      busWrite(ADDR_CTRL, {5'd0, filt, rise, 1'b1});
      busWrite(ADDR_CNT_HI, ldv[15:8]);
      busWrite(ADDR_CNT_LO, ldv[7:0]);
      capPin = nlv;
      repeat (lat - 2) @(negedge clk);
      chk(filt ? "R8 no capture before filter delay" : "R6 no capture before sync delay",
          {15'd0, capFlag}, 16'd0);
      @(negedge clk);
      chk(match ? "R6 capture flag" : "R7 wrong edge flag", {15'd0, capFlag}, {15'd0, match});
      expv = match ? (ldv + (filt ? 16'd6 : 16'd2)) : base;
      busRead(ADDR_CAP_LO, lo); busRead(ADDR_CAP_HI, hi);
      chk(match ? (filt ? "R8 filtered capture value" : "R6 capture value")
                : "R7 wrong edge keeps capture", {hi, lo}, expv);
    end

    // R8 short glitch rejected with filter, taken without
    capPin = 1'b0;
    repeat (8) @(negedge clk);
    busWrite(ADDR_CTRL, 8'h07);
    busWrite(ADDR_FLAG, 8'h03);
    capPin = 1'b1; repeat (2) @(negedge clk); capPin = 1'b0;
    repeat (12) @(negedge clk);
    chk("R8 glitch rejected", {15'd0, capFlag}, 16'd0);
    busWrite(ADDR_CTRL, 8'h03);
    capPin = 1'b1; repeat (2) @(negedge clk); capPin = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 glitch taken without filter", {15'd0, capFlag}, 16'd1);
    busWrite(ADDR_FLAG, 8'h02);
    chk("R5 capture flag cleared", {15'd0, capFlag}, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule